// File: doc/BRIEF.md
# Versatile interface timer and interrupt unit

This block is a memory-mapped peripheral with sixteen byte-wide register offsets. It provides two 8-bit I/O ports, each with its own direction register, and two 16-bit timers that count down once per clock. It also holds a shift register byte, an auxiliary control byte and a peripheral control byte, which are plain storage here. An interrupt flag register and an interrupt enable register combine into a single interrupt request output. A host reaches every register through a synchronous bus with a 4-bit offset, an 8-bit write bus, a read strobe and a write strobe. Read data follow the offset without delay. Any side effect of a read or a write takes place at the clock edge where the strobe is sampled high.

The timer flags are cleared as a by-product of ordinary bus traffic. Reading the low counter byte of a timer clears that timer's flag, and so does writing the timer's high byte. Timer 1 reloads its counter from a 16-bit latch each time it underflows, so it runs free at a period set by the latch. Timer 2 wraps to all ones and keeps counting. The enable register takes set and clear writes, chosen by the top bit of the written byte, so that software can change single enables without reading the register first.

Top module: `vti_unit`

## Requirements
- R1: After the synchronous reset, the following read as zero: both port output registers, both direction registers, the auxiliary control byte (offset 11), the peripheral control byte (offset 12) and the flag register (offset 13). The enable register (offset 14) reads 0x80, and irq is low.
- R2: Offset 1 holds the port A output byte, and offset 15 is an alias of offset 1. Offset 3 holds the port A direction byte. Offset 0 holds the port B output byte and offset 2 the port B direction byte. Reading a port returns the output bit where the direction bit is 1 and the input pin where it is 0. The output and direction registers appear on the output pins.
- R3: A write to offset 4 or offset 6 sets only the low byte of the timer 1 latch. A write to offset 7 sets the latch high byte and leaves the counter untouched. Offsets 6 and 7 read back the latch low and high bytes.
- R4: A write to offset 5 sets the latch high byte, loads the counter with the full 16-bit latch in the same edge and clears flag bit 6. The counter then falls by one each clock, and offsets 4 and 5 read its low and high bytes.
- R5: When timer 1 holds zero at a clock edge, flag bit 6 becomes 1 at that edge and the counter reloads from the latch.
- R6: A read strobe at offset 4 clears flag bit 6. A read strobe at offset 5 leaves the flags unchanged.
- R7: A write to offset 8 sets only the timer 2 low latch byte. A write to offset 9 loads the timer 2 counter with the written byte as its high half and the low latch as its low half, and clears flag bit 5. Offsets 8 and 9 read the counter. An edge at which the counter holds zero sets flag bit 5 and wraps the counter to 0xFFFF. A read strobe at offset 8 clears flag bit 5.
- R8: A write to offset 13 clears each flag bit written as 1 and keeps each flag bit written as 0.
- R9: A write to offset 14 with bit 7 set sets the enables written as 1 in bits 6:0. With bit 7 clear, it clears the enables written as 1. Bit 7 of an offset 14 read is always 1.
- R10: irq is high exactly when some bit is 1 in both the flags and the enables, and bit 7 of an offset 13 read equals irq.
- R11: A flag set by an underflow takes priority over a clear of that flag in the same edge. A counter load takes priority over the decrement or the underflow in the same edge.
- R12: Offsets 10, 11 and 12 store and read back the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; enables read side effects |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pa_in | input | 8 | Port A input pins |
| pa_out | output | 8 | Port A output register |
| pa_dir | output | 8 | Port A direction (1 = drive) |
| pb_in | input | 8 | Port B input pins |
| pb_out | output | 8 | Port B output register |
| pb_dir | output | 8 | Port B direction (1 = drive) |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two functions can act on timer 1 in the same cycle: the underflow that sets flag bit 6, and the read of offset 4 that clears it. The bench loads the counter with a small value, counts clocks until it holds zero, and holds the read strobe at offset 4 across exactly that edge. It then confirms that the flag stays set and that the read returned zero. A second case writes offset 5 at the edge where the counter is zero, and requires the new load value with no flag set.

// File: rtl/vti_pkg.sv
// Package: shared widths and register offsets of the timer/interrupt unit.
// Assumes a byte-wide bus and a 4-bit offset space.
package vti_pkg;
    localparam int DW = 8;
    localparam int AW = 4;

    typedef enum logic [AW-1:0] {
        RA_PB      = 4'd0,
        RA_PA      = 4'd1,
        RA_DIRB    = 4'd2,
        RA_DIRA    = 4'd3,
        RA_T1_LO   = 4'd4,
        RA_T1_HI   = 4'd5,
        RA_T1L_LO  = 4'd6,
        RA_T1L_HI  = 4'd7,
        RA_T2_LO   = 4'd8,
        RA_T2_HI   = 4'd9,
        RA_SHIFT   = 4'd10,
        RA_AUX     = 4'd11,
        RA_PERI    = 4'd12,
        RA_FLAG    = 4'd13,
        RA_ENAB    = 4'd14,
        RA_PA_ALT  = 4'd15
    } reg_addr_e;
endpackage

// File: rtl/vti_timer.sv
// Down counter: decrements once per clock, reports underflow when it holds
// zero, and then takes reload_val. A load has priority over everything.
// Assumes the caller presents load_val and reload_val as stable registers.
module vti_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic [TW-1:0] reload_val,
    output logic [TW-1:0] count,
    output logic          underflow
);
    // Underflow event: counter at zero and not being loaded this edge.
    assign underflow = (count == '0) && !load;

    // Counter update: load, reload on underflow, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)         count <= '1;
        else if (load)      count <= load_val;
        else if (underflow) count <= reload_val;
        else                count <= count - 1'b1;
    end
endmodule

// File: rtl/vti_port.sv
// One I/O port: output and direction registers, plus the pin-merged read
// value. Assumes pin_in is already synchronous to clk.
module vti_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         data_we,
    input  logic         dir_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] out_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] rd_val
);
    // Output register write.
    always_ff @(posedge clk) begin
        if (!rst_n)       out_q <= '0;
        else if (data_we) out_q <= wdata;
    end

    // Direction register write.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (dir_we) dir_q <= wdata;
    end

    // Read value: driven bits from the register, others from the pins.
    assign rd_val = (out_q & dir_q) | (pin_in & ~dir_q);
endmodule

// File: rtl/vti_irq.sv
// Interrupt flag and enable registers. Set requests beat clear requests in
// the same edge. Enable writes use the top bit of the data to select set or
// clear. Assumes set_vec and clr_vec are single-cycle requests.
module vti_irq #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic         en_wr,
    input  logic [N:0]   en_data,
    output logic [N-1:0] flags,
    output logic [N-1:0] enables,
    output logic         irq
);
    // Flag update: clear requested bits, then set bits win.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_vec) | set_vec;
    end

    // Enable update: set mode or clear mode picked by en_data[N].
    always_ff @(posedge clk) begin
        if (!rst_n)          enables <= '0;
        else if (en_wr) begin
            if (en_data[N])  enables <= enables | en_data[N-1:0];
            else             enables <= enables & ~en_data[N-1:0];
        end
    end

    // Request: any flag that is also enabled.
    assign irq = |(flags & enables);
endmodule

// File: rtl/vti_unit.sv
// Top of the timer/interrupt unit: decodes the byte bus, holds the timer
// latches and the plain control bytes, and muxes read data. Reads are
// combinational on bus_addr; side effects apply at the edge where bus_rd or
// bus_wr is high. Assumes bus_rd and bus_wr are not high together.
module vti_unit #(
    parameter int DW = vti_pkg::DW,
    parameter int AW = vti_pkg::AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    input  logic          bus_wr,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_dir,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_dir,
    output logic          irq
);
    import vti_pkg::*;

    localparam int TW      = 2 * DW;
    localparam int NF      = DW - 1;
    localparam int FLAG_T1 = NF - 1;
    localparam int FLAG_T2 = NF - 2;

    reg_addr_e      ra;
    logic [DW-1:0]  pa_rd, pb_rd;
    logic [TW-1:0]  t1_latch;
    logic [DW-1:0]  t2_latch_lo;
    logic [TW-1:0]  t1_count, t2_count;
    logic           t1_uf, t2_uf;
    logic           t1_load, t2_load;
    logic [DW-1:0]  sr_q, aux_q, peri_q;
    logic [NF-1:0]  ifr_bits, ier_bits;
    logic [NF-1:0]  set_vec, clr_vec;

    assign ra = reg_addr_e'(bus_addr);

    // Write strobe decode for a given offset.
    function automatic logic wr_at(input reg_addr_e a, input reg_addr_e t, input logic w);
        return w && (a == t);
    endfunction

    vti_port #(.W(DW)) u_port_a (
        .clk(clk), .rst_n(rst_n),
        .data_we(wr_at(ra, RA_PA, bus_wr) || wr_at(ra, RA_PA_ALT, bus_wr)),
        .dir_we(wr_at(ra, RA_DIRA, bus_wr)),
        .wdata(bus_wdata), .pin_in(pa_in),
        .out_q(pa_out), .dir_q(pa_dir), .rd_val(pa_rd)
    );

    vti_port #(.W(DW)) u_port_b (
        .clk(clk), .rst_n(rst_n),
        .data_we(wr_at(ra, RA_PB, bus_wr)),
        .dir_we(wr_at(ra, RA_DIRB, bus_wr)),
        .wdata(bus_wdata), .pin_in(pb_in),
        .out_q(pb_out), .dir_q(pb_dir), .rd_val(pb_rd)
    );

    // Timer 1 latch: low byte from two offsets, high byte from two offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) t1_latch <= '1;
        else begin
            if (wr_at(ra, RA_T1_LO, bus_wr) || wr_at(ra, RA_T1L_LO, bus_wr))
                t1_latch[DW-1:0] <= bus_wdata;
            if (wr_at(ra, RA_T1_HI, bus_wr) || wr_at(ra, RA_T1L_HI, bus_wr))
                t1_latch[TW-1:DW] <= bus_wdata;
        end
    end

    // Timer 2 low latch byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                        t2_latch_lo <= '1;
        else if (wr_at(ra, RA_T2_LO, bus_wr)) t2_latch_lo <= bus_wdata;
    end

    assign t1_load = wr_at(ra, RA_T1_HI, bus_wr);
    assign t2_load = wr_at(ra, RA_T2_HI, bus_wr);

    vti_timer #(.TW(TW)) u_timer1 (
        .clk(clk), .rst_n(rst_n), .load(t1_load),
        .load_val({bus_wdata, t1_latch[DW-1:0]}),
        .reload_val(t1_latch),
        .count(t1_count), .underflow(t1_uf)
    );

    vti_timer #(.TW(TW)) u_timer2 (
        .clk(clk), .rst_n(rst_n), .load(t2_load),
        .load_val({bus_wdata, t2_latch_lo}),
        .reload_val({TW{1'b1}}),
        .count(t2_count), .underflow(t2_uf)
    );

    // Plain control bytes: shift register, auxiliary and peripheral control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            aux_q  <= '0;
            peri_q <= '0;
        end else begin
            if (wr_at(ra, RA_SHIFT, bus_wr)) sr_q   <= bus_wdata;
            if (wr_at(ra, RA_AUX, bus_wr))   aux_q  <= bus_wdata;
            if (wr_at(ra, RA_PERI, bus_wr))  peri_q <= bus_wdata;
        end
    end

    // Flag set requests from the two timers.
    always_comb begin
        set_vec          = '0;
        set_vec[FLAG_T1] = t1_uf;
        set_vec[FLAG_T2] = t2_uf;
    end

    // Flag clear requests from bus side effects.
    always_comb begin
        clr_vec = '0;
        if (wr_at(ra, RA_FLAG, bus_wr)) clr_vec = bus_wdata[NF-1:0];
        if (wr_at(ra, RA_T1_LO, bus_rd) || t1_load) clr_vec[FLAG_T1] = 1'b1;
        if (wr_at(ra, RA_T2_LO, bus_rd) || t2_load) clr_vec[FLAG_T2] = 1'b1;
    end

    vti_irq #(.N(NF)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_vec(set_vec), .clr_vec(clr_vec),
        .en_wr(wr_at(ra, RA_ENAB, bus_wr)), .en_data(bus_wdata),
        .flags(ifr_bits), .enables(ier_bits), .irq(irq)
    );

    // Read data mux by offset.
    always_comb begin
        unique case (ra)
            RA_PB:               bus_rdata = pb_rd;
            RA_PA, RA_PA_ALT:    bus_rdata = pa_rd;
            RA_DIRB:             bus_rdata = pb_dir;
            RA_DIRA:             bus_rdata = pa_dir;
            RA_T1_LO:            bus_rdata = t1_count[DW-1:0];
            RA_T1_HI:            bus_rdata = t1_count[TW-1:DW];
            RA_T1L_LO:           bus_rdata = t1_latch[DW-1:0];
            RA_T1L_HI:           bus_rdata = t1_latch[TW-1:DW];
            RA_T2_LO:            bus_rdata = t2_count[DW-1:0];
            RA_T2_HI:            bus_rdata = t2_count[TW-1:DW];
            RA_SHIFT:            bus_rdata = sr_q;
            RA_AUX:              bus_rdata = aux_q;
            RA_PERI:             bus_rdata = peri_q;
            RA_FLAG:             bus_rdata = {irq, ifr_bits};
            RA_ENAB:             bus_rdata = {1'b1, ier_bits};
            default:             bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/vti_unit_chk.sv
// Checker for vti_unit: temporal properties on the bus, timer 1 state and
// the flag register. Bound into every vti_unit instance.
module vti_unit_chk #(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic            bus_wr,
    input logic [DW-1:0]   bus_rdata,
    input logic            irq,
    input logic [2*DW-1:0] t1_count,
    input logic [2*DW-1:0] t1_latch,
    input logic [DW-2:0]   flags
);
    // R1: the first edge after reset release sees a quiet flag register.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags == '0) && !irq);

    // R9: the enable register always reads with its top bit set.
    a_r9_enable_top: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 4'd14) |-> bus_rdata[DW-1]);

    // R10: the summary bit of a flag read mirrors the request output.
    a_r10_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 4'd13) |-> (bus_rdata[DW-1] == irq));

    // R4: a high-byte write loads the counter and clears flag bit 6.
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd5) |=>
            (t1_count == {$past(bus_wdata), $past(t1_latch[DW-1:0])}) && !flags[DW-2]);

    // R5, R11: zero count without a load sets bit 6 and reloads the latch.
    a_r5_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_count == '0) && !(bus_wr && bus_addr == 4'd5) |=>
            flags[DW-2] && (t1_count == $past(t1_latch)));

    // R8: writing 1 to bit 6 of the flag register clears it when no underflow.
    a_r8_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd13 && bus_wdata[DW-2] && t1_count != '0) |=> !flags[DW-2]);
endmodule

bind vti_unit vti_unit_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .irq(irq),
    .t1_count(t1_count), .t1_latch(t1_latch), .flags(ifr_bits)
);

// File: tb/test_vti_unit.sv
// Directed bench for vti_unit: one task per scenario, each checking itself.
module test_vti_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pa_in = '0, pb_in = '0;
    logic [7:0] pa_out, pa_dir, pb_out, pb_dir;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vti_unit i_vti_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir),
        .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Write: strobe held across exactly one rising edge.
    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Strobed read: sample before the edge, side effect at the edge.
    task automatic do_rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Peek: unstrobed read, no side effect, no clock.
    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        peek(4'd13, v); check("R1 flags", v, 8'h00);
        peek(4'd14, v); check("R1 enables", v, 8'h80);
        peek(4'd11, v); check("R1 aux", v, 8'h00);
        peek(4'd12, v); check("R1 peri", v, 8'h00);
        check("R1 ports", {pa_out, pb_out}, 16'h0000);
        check("R1 dirs", {pa_dir, pb_dir}, 16'h0000);
        check("R1 irq", irq, 1'b0);
    endtask

    task automatic t_ports;
        logic [7:0] v;
        do_wr(4'd3, 8'hF0);
        do_wr(4'd1, 8'hA5);
        pa_in = 8'h3C;
        peek(4'd1, v);  check("R2 port A merge", v, 8'hAC);
        peek(4'd15, v); check("R2 port A alias", v, 8'hAC);
        check("R2 port A pins", {pa_out, pa_dir}, 16'hA5F0);
        do_wr(4'd2, 8'h0F);
        do_wr(4'd0, 8'h96);
        pb_in = 8'hF0;
        peek(4'd0, v);  check("R2 port B merge", v, 8'hF6);
        peek(4'd2, v);  check("R2 port B dir read", v, 8'h0F);
        do_wr(4'd15, 8'h5A);
        check("R2 alias write", pa_out, 8'h5A);
    endtask

    task automatic t_misc;
        logic [7:0] v;
        do_wr(4'd10, 8'h5A);
        do_wr(4'd11, 8'h33);
        do_wr(4'd12, 8'hC3);
        peek(4'd10, v); check("R12 shift", v, 8'h5A);
        peek(4'd11, v); check("R12 aux", v, 8'h33);
        peek(4'd12, v); check("R12 peri", v, 8'hC3);
    endtask

    task automatic t_enable;
        logic [7:0] v;
        do_wr(4'd14, 8'h83); peek(4'd14, v); check("R9 set", v, 8'h83);
        do_wr(4'd14, 8'h01); peek(4'd14, v); check("R9 clear", v, 8'h82);
        do_wr(4'd14, 8'hFF); peek(4'd14, v); check("R9 set all", v, 8'hFF);
        do_wr(4'd14, 8'h7F); peek(4'd14, v); check("R9 clear all", v, 8'h80);
    endtask

    task automatic t_t1_run;
        logic [7:0] v;
        do_wr(4'd4, 8'h34);
        do_wr(4'd5, 8'h12);
        peek(4'd4, v); check("R4 load low", v, 8'h34);
        peek(4'd5, v); check("R4 load high", v, 8'h12);
        repeat (3) @(negedge clk);
        peek(4'd4, v); check("R4 decrement", v, 8'h31);
        peek(4'd6, v); check("R3 latch low", v, 8'h34);
        peek(4'd7, v); check("R3 latch high", v, 8'h12);
        do_wr(4'd6, 8'h78);
        peek(4'd6, v); check("R3 offset 6 latch", v, 8'h78);
        peek(4'd4, v); check("R3 offset 6 no load", v, 8'h30);
    endtask

    task automatic t_t1_flag;
        logic [7:0] v;
        do_wr(4'd14, 8'h7F);
        do_wr(4'd13, 8'h7F);
        do_wr(4'd6, 8'h03);
        do_wr(4'd5, 8'h00);
        peek(4'd13, v); check("R4 flag cleared by load", v, 8'h00);
        do_wr(4'd6, 8'hFF);
        do_wr(4'd7, 8'hFF);
        @(negedge clk);
        peek(4'd4, v);  check("R3 offset 7 no load", v, 8'h00);
        peek(4'd13, v); check("R5 no flag at zero", v, 8'h00);
        @(negedge clk);
        peek(4'd13, v); check("R5 flag on underflow", v, 8'h40);
        peek(4'd5, v);  check("R5 reload high", v, 8'hFF);
        peek(4'd4, v);  check("R5 reload low", v, 8'hFF);
        check("R10 irq masked", irq, 1'b0);
        do_wr(4'd14, 8'hC0);
        check("R10 irq enabled", irq, 1'b1);
        peek(4'd13, v); check("R10 summary bit", v, 8'hC0);
        do_rd(4'd5, v);
        peek(4'd13, v); check("R6 offset 5 read keeps flag", v, 8'hC0);
        do_wr(4'd14, 8'h40);
        check("R10 irq after disable", irq, 1'b0);
        peek(4'd13, v); check("R10 summary off", v, 8'h40);
        do_wr(4'd14, 8'hC0);
        do_rd(4'd4, v);
        peek(4'd13, v); check("R6 offset 4 read clears", v, 8'h00);
        check("R6 irq after read", irq, 1'b0);
        do_wr(4'd14, 8'h7F);
    endtask

    task automatic t_t2;
        logic [7:0] v;
        do_wr(4'd8, 8'h02);
        do_wr(4'd9, 8'h00);
        peek(4'd8, v); check("R7 load low", v, 8'h02);
        peek(4'd9, v); check("R7 load high", v, 8'h00);
        repeat (2) @(negedge clk);
        peek(4'd13, v); check("R7 no flag at zero", v, 8'h00);
        @(negedge clk);
        peek(4'd13, v); check("R7 flag on underflow", v, 8'h20);
        peek(4'd9, v);  check("R7 wrap high", v, 8'hFF);
        do_wr(4'd13, 8'h40);
        peek(4'd13, v); check("R8 zero bit kept", v, 8'h20);
        do_wr(4'd13, 8'h20);
        peek(4'd13, v); check("R8 one bit cleared", v, 8'h00);
        do_wr(4'd8, 8'h00);
        do_wr(4'd9, 8'h00);
        @(negedge clk);
        peek(4'd13, v); check("R7 flag again", v, 8'h20);
        do_rd(4'd8, v);
        peek(4'd13, v); check("R7 offset 8 read clears", v, 8'h00);
    endtask

    task automatic t_collide;
        logic [7:0] v;
        do_wr(4'd13, 8'h7F);
        do_wr(4'd6, 8'h03);
        do_wr(4'd5, 8'h00);
        do_wr(4'd7, 8'hFF);
        repeat (2) @(negedge clk);
        do_rd(4'd4, v);
        check("R11 read at zero returns zero", v, 8'h00);
        peek(4'd13, v); check("R11 set beats read clear", v, 8'h40);
        peek(4'd5, v);  check("R11 reload high", v, 8'hFF);
        peek(4'd4, v);  check("R11 reload low", v, 8'h03);
        do_wr(4'd6, 8'h02);
        do_wr(4'd5, 8'h00);
        peek(4'd13, v); check("R4 write clears flag", v, 8'h00);
        repeat (2) @(negedge clk);
        do_wr(4'd5, 8'h00);
        peek(4'd13, v); check("R11 load beats underflow", v, 8'h00);
        peek(4'd4, v);  check("R11 load value", v, 8'h02);
        do_wr(4'd6, 8'hFF);
        do_wr(4'd5, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ports();
        t_misc();
        t_enable();
        t_t1_run();
        t_t1_flag();
        t_t2();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule